// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Sequencer

This block carries out single read or write transfers on a shared address/data bus. The processor core offers one request at a time. A request gives a 20-bit address, a memory or I/O choice, a byte or word size, write data, a two-bit segment code and the current interrupt-enable state. The sequencer moves through four bus phases, called T1 to T4. It puts the address on the shared lines in T1 and pulses the address latch strobe. From T2 on it uses the upper four lines for status. A read releases the lower lines in T2, and a write drives its data onto them from T2.

Read, write and transceiver strobes are active from T2 until the ready input is seen high at the end of T3 or of a wait state. The bank-high enable and address bit 0 together choose which byte lanes take part. A word at an odd address cannot be moved in one transfer, so the block splits it into two byte transfers. A hold request from another bus master is granted only between transfers. While the grant lasts, every strobe is inactive and the lower lines are released.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is high and afterwards until a request arrives, the block is idle: addrLatch low, rdStrobeN, wrStrobeN and xcvrEnN high, adOe low, holdAck low, reqReady high (with holdReq low).
- R2: With waitReady high, a transfer takes four cycles after the accepting edge: T1, T2, T3, T4. addrLatch is high only in T1, and done is high in T4 of the last transfer.
- R3: waitReady is sampled at the end of T3 and of every wait state. Each low sample inserts one more wait cycle, in which the strobes stay active.
- R4: In T1, adOut carries address bits 15..0 with adOe high. upperOut carries address bits 19..16 for memory transfers and 0000 for I/O transfers.
- R5: From T2 through T4, upperOut is {0, interrupt enable, segment[1:0]}. Segment code 00 means extra, 01 stack, 10 code or none, 11 data.
- R6: bankHighN is 0 for an aligned word and for an odd byte. It is 1 for an even byte. The pair bankHighN=1 with address bit 0 =1 (no transfer) never appears in T1.
- R7: In T2, T3 and wait cycles, rdStrobeN is low for reads, wrStrobeN is low for writes, and xcvrEnN is low for both. During T1 to T4, xcvrTx is high for writes and low for reads, and memSel is 1 for memory and 0 for I/O.
- R8: A write drives adOut from T2 through T4. An aligned word appears as is, and a byte appears copied onto both lanes (bits 15..8 and 7..0).
- R9: Read data is captured on the edge that ends the strobes. A word takes adIn whole, an even byte takes adIn[7..0], and an odd byte takes adIn[15..8], zero-extended into rdData.
- R10: A word at an odd address runs as two transfers. The first is an odd byte at the given address and carries data bits 7..0. The second is an even byte at the address plus one, wrapping at 20 bits, and carries data bits 15..8. done comes only after the second transfer, seven cycles after acceptance.
- R11: A hold request is granted only from idle or at the end of T4. holdAck rises the next cycle, all strobes stay inactive with adOe low while it is high, and it falls the cycle after holdReq drops. A split transfer then continues with its second half.
- R12: A request is accepted only while reqReady is high, which is when the block is idle and holdReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, held at least 4 cycles |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 write, 0 read |
| reqMem | input | 1 | 1 memory, 0 I/O |
| reqWord | input | 1 | 1 word, 0 byte |
| reqAddr | input | 20 | Byte address |
| reqData | input | 16 | Write data (byte in bits 7..0) |
| reqSeg | input | 2 | Segment code for status |
| reqIntEn | input | 1 | Interrupt-enable state for status |
| reqReady | output | 1 | Request will be accepted this cycle |
| done | output | 1 | Last T4 of the request |
| rdData | output | 16 | Captured read data |
| adOut | output | 16 | Shared lines, driven value |
| adOe | output | 1 | Shared lines drive enable |
| adIn | input | 16 | Shared lines, received value |
| upperOut | output | 4 | Upper address / status lines |
| bankHighN | output | 1 | Odd bank enable, active low |
| addrLatch | output | 1 | Address latch strobe, active high |
| rdStrobeN | output | 1 | Read strobe, active low |
| wrStrobeN | output | 1 | Write strobe, active low |
| xcvrTx | output | 1 | Transceiver direction, 1 transmit |
| xcvrEnN | output | 1 | Transceiver enable, active low |
| memSel | output | 1 | 1 memory, 0 I/O |
| waitReady | input | 1 | Slave ready |
| holdReq | input | 1 | Bus hold request |
| holdAck | output | 1 | Bus hold grant |

## Verification
The bench runs reads and writes of every size and alignment. An aligned word, an odd byte and an even byte each select a different bank-enable value and lane, so a swapped lane shows in rdData or adOut. Wait counts of 0, 1 and 2 separate correct ready sampling from an off-by-one in the wait loop. An odd-address word at the top of the address space checks the split order and the address wrap. A hold raised in the middle of a split read, and a hold raised while a request waits in idle, show whether the grant lands only at T4 or idle, and whether the second half resumes afterwards.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_HOLD
  } phase_e;

  typedef struct packed {
    logic load;        // request accepted this cycle
    logic addrPh;      // T1
    logic dataPh;      // T2, T3, wait
    logic endPh;       // T4
    logic capture;     // strobes end on this edge
    logic secondHalf;  // second byte of a split word
  } seqStrobes_t;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        holdReq,
  input  logic        waitReady,
  input  logic        splitReq,
  output seqStrobes_t stb,
  output logic        reqReady,
  output logic        holdAck,
  output logic        done
);

  phase_e state, nextState;
  logic   secondHalf;

  assign reqReady = (state == PH_IDLE) && !holdReq;
  assign holdAck  = (state == PH_HOLD);
  assign done     = (state == PH_T4) && (!splitReq || secondHalf);

  always_comb begin
    nextState = state;
    unique case (state)
      PH_IDLE: if (holdReq) nextState = PH_HOLD;
               else if (reqValid) nextState = PH_T1;
      PH_T1:   nextState = PH_T2;
      PH_T2:   nextState = PH_T3;
      PH_T3,
      PH_TW:   nextState = waitReady ? PH_T4 : PH_TW;
      PH_T4:   if (holdReq) nextState = PH_HOLD;
               else if (splitReq && !secondHalf) nextState = PH_T1;
               else nextState = PH_IDLE;
      PH_HOLD: if (!holdReq) nextState = secondHalf ? PH_T1 : PH_IDLE;
      default: nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PH_IDLE;
      secondHalf <= 1'b0;
    end else begin
      state <= nextState;
      if (reqReady && reqValid) secondHalf <= 1'b0;
      else if (state == PH_T4)  secondHalf <= splitReq && !secondHalf;
    end
  end

  always_comb begin
    stb.load       = reqReady && reqValid;
    stb.addrPh     = (state == PH_T1);
    stb.dataPh     = (state == PH_T2) || (state == PH_T3) || (state == PH_TW);
    stb.endPh      = (state == PH_T4);
    stb.capture    = ((state == PH_T3) || (state == PH_TW)) && waitReady;
    stb.secondHalf = secondHalf;
  end

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  seqStrobes_t                stb,
  input  logic                       reqWrite,
  input  logic                       reqMem,
  input  logic                       reqWord,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic [DATA_W-1:0]          reqData,
  input  logic [1:0]                 reqSeg,
  input  logic                       reqIntEn,
  input  logic [DATA_W-1:0]          adIn,
  output logic                       splitReq,
  output logic [DATA_W-1:0]          rdData,
  output logic [DATA_W-1:0]          adOut,
  output logic                       adOe,
  output logic [ADDR_W-DATA_W-1:0]   upperOut,
  output logic                       bankHighN,
  output logic                       addrLatch,
  output logic                       rdStrobeN,
  output logic                       wrStrobeN,
  output logic                       xcvrTx,
  output logic                       xcvrEnN,
  output logic                       memSel
);

  localparam int LANE_W  = DATA_W / 2;
  localparam int UPPER_W = ADDR_W - DATA_W;

  logic              rWrite, rMem, rWord, rIntEn;
  logic [1:0]        rSeg;
  logic [ADDR_W-1:0] rAddr, curAddr;
  logic [DATA_W-1:0] rData, laneData;
  logic              active, busPh;

  assign splitReq = rWord && rAddr[0];
  assign curAddr  = rAddr + ADDR_W'(stb.secondHalf);
  assign active   = stb.addrPh || stb.dataPh || stb.endPh;
  assign busPh    = stb.dataPh || stb.endPh;

  always_ff @(posedge clk) begin
    if (rst) begin
      rWrite <= 1'b0; rMem <= 1'b0; rWord <= 1'b0; rIntEn <= 1'b0;
      rSeg   <= '0;   rAddr <= '0;  rData <= '0;   rdData <= '0;
    end else if (stb.load) begin
      rWrite <= reqWrite; rMem  <= reqMem;  rWord <= reqWord;
      rIntEn <= reqIntEn; rSeg  <= reqSeg;  rAddr <= reqAddr;
      rData  <= reqData;  rdData <= '0;
    end else if (stb.capture && !rWrite) begin
      if (splitReq) begin
        if (stb.secondHalf) rdData[DATA_W-1:LANE_W] <= adIn[LANE_W-1:0];
        else                rdData[LANE_W-1:0]      <= adIn[DATA_W-1:LANE_W];
      end else if (rWord) begin
        rdData <= adIn;
      end else if (rAddr[0]) begin
        rdData <= {{LANE_W{1'b0}}, adIn[DATA_W-1:LANE_W]};
      end else begin
        rdData <= {{LANE_W{1'b0}}, adIn[LANE_W-1:0]};
      end
    end
  end

  always_comb begin
    if (rWord && !rAddr[0])
      laneData = rData;
    else if (splitReq && stb.secondHalf)
      laneData = {2{rData[DATA_W-1:LANE_W]}};
    else
      laneData = {2{rData[LANE_W-1:0]}};
  end

  always_comb begin
    adOut    = '0;
    adOe     = 1'b0;
    upperOut = '0;
    if (stb.addrPh) begin
      adOut    = curAddr[DATA_W-1:0];
      adOe     = 1'b1;
      upperOut = rMem ? curAddr[ADDR_W-1:DATA_W] : {UPPER_W{1'b0}};
    end else if (busPh) begin
      upperOut[1:0] = rSeg;
      upperOut[2]   = rIntEn;
      if (rWrite) begin
        adOut = laneData;
        adOe  = 1'b1;
      end
    end
  end

  always_comb begin
    if (!active)       bankHighN = 1'b1;
    else if (splitReq) bankHighN = stb.secondHalf;
    else if (rWord)    bankHighN = 1'b0;
    else               bankHighN = ~rAddr[0];
  end

  assign addrLatch = stb.addrPh;
  assign rdStrobeN = !(stb.dataPh && !rWrite);
  assign wrStrobeN = !(stb.dataPh && rWrite);
  assign xcvrEnN   = !stb.dataPh;
  assign xcvrTx    = active && rWrite;
  assign memSel    = active ? rMem : 1'b1;

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic                     reqWord,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqData,
  input  logic [1:0]               reqSeg,
  input  logic                     reqIntEn,
  output logic                     reqReady,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] upperOut,
  output logic                     bankHighN,
  output logic                     addrLatch,
  output logic                     rdStrobeN,
  output logic                     wrStrobeN,
  output logic                     xcvrTx,
  output logic                     xcvrEnN,
  output logic                     memSel,
  input  logic                     waitReady,
  input  logic                     holdReq,
  output logic                     holdAck
);

  seqStrobes_t stb;
  logic        splitReq;

  bcs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .holdReq(holdReq),
    .waitReady(waitReady), .splitReq(splitReq), .stb(stb),
    .reqReady(reqReady), .holdAck(holdAck), .done(done)
  );

  bcs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .reqWrite(reqWrite), .reqMem(reqMem), .reqWord(reqWord),
    .reqAddr(reqAddr), .reqData(reqData), .reqSeg(reqSeg), .reqIntEn(reqIntEn),
    .adIn(adIn), .splitReq(splitReq), .rdData(rdData),
    .adOut(adOut), .adOe(adOe), .upperOut(upperOut), .bankHighN(bankHighN),
    .addrLatch(addrLatch), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .xcvrTx(xcvrTx), .xcvrEnN(xcvrEnN), .memSel(memSel)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic clk,
  input logic rst,
  input logic addrLatch,
  input logic rdStrobeN,
  input logic wrStrobeN,
  input logic xcvrEnN,
  input logic adOe,
  input logic adOut0,
  input logic bankHighN,
  input logic waitReady,
  input logic holdReq,
  input logic holdAck,
  input logic reqReady,
  input logic done
);

  // R2
  ale_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    addrLatch |=> !addrLatch);

  // R2
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    addrLatch |=> !xcvrEnN);

  // R2
  done_idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (xcvrEnN && !addrLatch));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rdStrobeN || wrStrobeN);

  // R3
  wait_stretch_chk: assert property (@(posedge clk) disable iff (rst)
    (!xcvrEnN && !waitReady) |=> !xcvrEnN);

  // R6
  lane_valid_chk: assert property (@(posedge clk) disable iff (rst)
    addrLatch |-> !(bankHighN && adOut0));

  // R11
  hold_release_chk: assert property (@(posedge clk) disable iff (rst)
    holdAck |-> (rdStrobeN && wrStrobeN && !adOe && !addrLatch));

  // R11
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (holdAck && !holdReq) |=> !holdAck);

  // R11
  hold_no_midcycle_chk: assert property (@(posedge clk) disable iff (rst)
    !xcvrEnN |=> !holdAck);

  // R12
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> (!holdAck && !holdReq));

endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (
  .clk(clk), .rst(rst), .addrLatch(addrLatch), .rdStrobeN(rdStrobeN),
  .wrStrobeN(wrStrobeN), .xcvrEnN(xcvrEnN), .adOe(adOe), .adOut0(adOut[0]),
  .bankHighN(bankHighN), .waitReady(waitReady), .holdReq(holdReq),
  .holdAck(holdAck), .reqReady(reqReady), .done(done)
);

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        reqValid = 0, reqWrite = 0, reqMem = 0, reqWord = 0, reqIntEn = 0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqData = '0, adIn = '0;
  logic [1:0]  reqSeg = '0;
  logic        waitReady = 1, holdReq = 0;
  logic        reqReady, done, adOe, bankHighN, addrLatch, rdStrobeN, wrStrobeN;
  logic        xcvrTx, xcvrEnN, memSel, holdAck;
  logic [15:0] rdData, adOut;
  logic [3:0]  upperOut;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqData(reqData), .reqSeg(reqSeg),
    .reqIntEn(reqIntEn), .reqReady(reqReady), .done(done), .rdData(rdData),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .upperOut(upperOut),
    .bankHighN(bankHighN), .addrLatch(addrLatch), .rdStrobeN(rdStrobeN),
    .wrStrobeN(wrStrobeN), .xcvrTx(xcvrTx), .xcvrEnN(xcvrEnN), .memSel(memSel),
    .waitReady(waitReady), .holdReq(holdReq), .holdAck(holdAck)
  );

  int checks = 0, failures = 0;

  task automatic chkEq(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int M_IDLE = 0, M_T1 = 1, M_T2 = 2, M_T3 = 3, M_TW = 4, M_T4 = 5, M_HOLD = 6;
  int          mState = M_IDLE;
  bit          mWrite, mMem, mWord, mIe, mSecond, mAcc, modelOn;
  logic [1:0]  mSeg;
  logic [19:0] mAddr;
  logic [15:0] mData, mRd;
  int          cycleCnt = 0, lastAccept = 0;

  always @(posedge clk) begin
    bit split;
    cycleCnt++;
    mAcc  = 0;
    split = mWord && mAddr[0];
    if (rst) begin
      mState = M_IDLE; mSecond = 0; mRd = 0;
      mWrite = 0; mMem = 0; mWord = 0; mIe = 0; mSeg = 0; mAddr = 0; mData = 0;
    end else begin
      case (mState)
        M_IDLE: if (holdReq) mState = M_HOLD;
                else if (reqValid) begin
                  mWrite = reqWrite; mMem = reqMem; mWord = reqWord; mIe = reqIntEn;
                  mSeg = reqSeg; mAddr = reqAddr; mData = reqData; mRd = 0;
                  mSecond = 0; mState = M_T1; mAcc = 1; lastAccept = cycleCnt;
                end
        M_T1: mState = M_T2;
        M_T2: mState = M_T3;
        M_T3, M_TW: if (waitReady) begin
                  if (!mWrite) begin
                    if (split && !mSecond) mRd[7:0] = adIn[15:8];
                    else if (split)        mRd[15:8] = adIn[7:0];
                    else if (mWord)        mRd = adIn;
                    else if (mAddr[0])     mRd = {8'h00, adIn[15:8]};
                    else                   mRd = {8'h00, adIn[7:0]};
                  end
                  mState = M_T4;
                end else mState = M_TW;
        M_T4: begin
                if (split && !mSecond) begin
                  mSecond = 1;
                  mState  = holdReq ? M_HOLD : M_T1;
                end else begin
                  mSecond = 0;
                  mState  = holdReq ? M_HOLD : M_IDLE;
                end
              end
        M_HOLD: if (!holdReq) mState = mSecond ? M_T1 : M_IDLE;
        default: mState = M_IDLE;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit          act, strobe, split;
    logic [19:0] cur;
    logic [15:0] eAd, lanes;
    logic [3:0]  eUp;
    bit          eOe, eBhe;
    if (modelOn && !rst) begin
      act    = (mState >= M_T1) && (mState <= M_T4);
      strobe = (mState == M_T2) || (mState == M_T3) || (mState == M_TW);
      split  = mWord && mAddr[0];
      cur    = mSecond ? mAddr + 20'd1 : mAddr;
      if (mWord && !mAddr[0]) lanes = mData;
      else if (split && mSecond) lanes = {mData[15:8], mData[15:8]};
      else lanes = {mData[7:0], mData[7:0]};
      eAd = 16'h0; eOe = 0; eUp = 4'h0;
      if (mState == M_T1) begin
        eAd = cur[15:0]; eOe = 1; eUp = mMem ? cur[19:16] : 4'h0;
      end else if (act) begin
        eUp = {1'b0, mIe, mSeg};
        if (mWrite) begin eAd = lanes; eOe = 1; end
      end
      if (!act) eBhe = 1;
      else if (split) eBhe = mSecond;
      else if (mWord) eBhe = 0;
      else eBhe = ~mAddr[0];
      chkEq("R2", "addrLatch", addrLatch, mState == M_T1);
      chkEq(mState == M_T1 ? "R4" : "R8", "adOe", adOe, eOe);
      chkEq(mState == M_T1 ? "R4" : "R8", "adOut", adOut, eAd);
      chkEq(mState == M_T1 ? "R4" : "R5", "upperOut", upperOut, eUp);
      chkEq("R6", "bankHighN", bankHighN, eBhe);
      chkEq("R7", "rdStrobeN", rdStrobeN, !(strobe && !mWrite));
      chkEq("R7", "wrStrobeN", wrStrobeN, !(strobe && mWrite));
      chkEq("R7", "xcvrEnN", xcvrEnN, !strobe);
      chkEq("R7", "xcvrTx", xcvrTx, act && mWrite);
      chkEq("R7", "memSel", memSel, act ? mMem : 1'b1);
      chkEq("R9", "rdData", rdData, mRd);
      chkEq("R2", "done", done, (mState == M_T4) && (!split || mSecond));
      chkEq("R11", "holdAck", holdAck, mState == M_HOLD);
      chkEq("R12", "reqReady", reqReady, (mState == M_IDLE) && !holdReq);
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendReq(bit w, bit m, bit wd, logic [19:0] a, logic [15:0] d,
                         logic [1:0] s, bit ie, int waits);
    @(negedge clk); #1;
    reqValid = 1; reqWrite = w; reqMem = m; reqWord = wd; reqAddr = a;
    reqData = d; reqSeg = s; reqIntEn = ie; waitReady = (waits == 0);
    forever begin
      @(posedge clk); #1;
      if (mAcc) break;
    end
    reqValid = 0;
    if (waits > 0) begin
      repeat (2 + waits) @(posedge clk);
      #1 waitReady = 1;
    end
  endtask

  task automatic waitDone(string tag, int expLat);
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (done) break;
    end
    chkEq(tag, "done latency", cycleCnt - lastAccept, expLat);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chkEq("R1", "addrLatch", addrLatch, 0);
    chkEq("R1", "rdStrobeN", rdStrobeN, 1);
    chkEq("R1", "wrStrobeN", wrStrobeN, 1);
    chkEq("R1", "xcvrEnN", xcvrEnN, 1);
    chkEq("R1", "adOe", adOe, 0);
    chkEq("R1", "holdAck", holdAck, 0);
    #1 rst = 0;
    @(negedge clk);
    chkEq("R1", "reqReady", reqReady, 1);
    modelOn = 1;

    // R2 R9: aligned memory word read, no waits, data segment
    adIn = 16'hBEEF;
    sendReq(0, 1, 1, 20'h12344, 16'h0, 2'b11, 1, 0);
    waitDone("R2", 3);
    chkEq("R9", "word read", rdData, 16'hBEEF);

    // R3 R6 R8: odd byte memory write, two waits
    sendReq(1, 1, 0, 20'hABCD1, 16'h005A, 2'b01, 0, 2);
    waitDone("R3", 5);

    // R4 R9: I/O even byte read, one wait
    adIn = 16'h7733;
    sendReq(0, 0, 0, 20'h000F0, 16'h0, 2'b10, 1, 1);
    waitDone("R3", 4);
    chkEq("R9", "even byte read", rdData, 16'h0033);

    // R9: I/O odd byte read
    sendReq(0, 0, 0, 20'h000F1, 16'h0, 2'b00, 0, 0);
    waitDone("R2", 3);
    chkEq("R9", "odd byte read", rdData, 16'h0077);

    // R10: split word write at top of address space, wraps
    sendReq(1, 1, 1, 20'hFFFFF, 16'hC3A5, 2'b11, 1, 0);
    waitDone("R10", 7);

    // R10 R11: split word read with hold raised in T2 of the first half
    adIn = 16'h9A5C;
    sendReq(0, 1, 1, 20'h01233, 16'h0, 2'b01, 1, 0);
    @(posedge clk); #1 holdReq = 1;
    repeat (6) @(posedge clk);
    #1 chkEq("R11", "holdAck granted after T4", holdAck, 1);
    holdReq = 0;
    waitDone("R10", 11);
    chkEq("R10", "split read", rdData, 16'h5C9A);

    // R11 R12: hold in idle blocks a waiting request
    @(negedge clk); #1;
    holdReq = 1; reqValid = 1; reqWrite = 1; reqMem = 1; reqWord = 1;
    reqAddr = 20'h40000; reqData = 16'h1234; reqSeg = 2'b10; reqIntEn = 0;
    @(negedge clk);
    chkEq("R11", "holdAck from idle", holdAck, 1);
    chkEq("R12", "reqReady under hold", reqReady, 0);
    repeat (3) @(negedge clk);
    chkEq("R12", "no bus activity under hold", addrLatch, 0);
    #1 holdReq = 0;
    forever begin
      @(posedge clk); #1;
      if (mAcc) break;
    end
    reqValid = 0;
    waitDone("R2", 3);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule